// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block models the digital control of a linear image sensor with a parameterised number of pixels (128 by default). A single serial start bit does two jobs. First, it freezes the value of every pixel at the same moment. Second, it starts an output scan. During the scan a one-hot select walks from the first pixel to the last, one pixel per clock. A global integrator-reset level stays high for a fixed number of clocks at the start of the scan, and then integration of the next frame begins.

An output-enable signal stands in for the tri-state analog output. After the last pixel, one more terminating clock is needed: the select then drains out and the output goes idle. The analog parts are represented by a parallel pixel-value input bus. Each start captures this bus, and the select routes the captured value of the selected pixel to a digital output, so the scan order can be observed.

A per-pixel vector shows when each sampling path is reconnected to its integrator. A start that arrives while a scan is running is dropped, and a sticky error flag is raised.

Top module: `line_readout_seq`

## Requirements
- R1: While `rstN` is low at a rising edge, and on every following cycle until a start, `pixSel` is 0, `outEn`, `holdStb`, `intReset` and `protoErr` are 0, and `sampleConn` is all ones.
- R2: When `startIn` is high at a rising edge while no scan is running, `holdStb` is high for exactly the one following cycle. The whole `pixData` bus is captured at that edge, so later changes of `pixData` do not alter `pixOut` during the scan.
- R3: In cycle k after the start edge (k = 1 to NUM_PIX), `pixSel` equals 1 << (k-1), with bit 0 being pixel 1. `pixOut` equals the captured field `pixData[(k-1)*PIX_W +: PIX_W]`.
- R4: `intReset` is high for exactly RST_CLKS cycles (default 18), starting in the cycle after the start edge. It falls on the (RST_CLKS+1)th edge of the scan.
- R5: `outEn` is high for exactly NUM_PIX cycles. On the (NUM_PIX+1)th edge of the scan, `outEn` falls and `pixSel` returns to 0.
- R6: Whenever no scan is running, `outEn` is 0 and `pixOut` is 0.
- R7: From the cycle after the start edge, `sampleConn` is all zeros. Pixels 1 to RST_CLKS are reconnected together on the (RST_CLKS+1)th edge. Any later pixel j is reconnected on edge j+1. After the terminating edge all bits are one.
- R8: A start sampled while a scan is running leaves the scan unchanged and sets `protoErr`. `protoErr` then stays high until `rstN` is low.
- R9: A start sampled in the first idle cycle after the terminating edge is accepted and begins a full new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Serial start bit, one clock wide |
| pixData | input | NUM_PIX*PIX_W | Live pixel values; field i belongs to pixel i+1 |
| pixSel | output | NUM_PIX | One-hot pixel select, bit 0 = pixel 1 |
| holdStb | output | 1 | One-cycle pulse marking the simultaneous capture |
| intReset | output | 1 | Global integrator reset level |
| outEn | output | 1 | Output driven (low stands for high impedance) |
| pixOut | output | PIX_W | Captured value of the selected pixel, 0 when idle |
| sampleConn | output | NUM_PIX | Per-pixel sampling path connected to its integrator |
| protoErr | output | 1 | Sticky flag: start arrived during a scan |

## Verification
The assertions assume that `startIn` behaves as a clean synchronous pulse, high for a single sampled edge. They also assume that `rstN` is held low for at least one edge before any start. The stimulus drives `startIn` only on falling clock edges and always lowers it at the next falling edge, so every start is seen at exactly one rising edge. The one deliberate exception is a pulse placed mid-scan, which tests the rejection path. The pixel bus is changed only while a scan is in progress, to show that the captured values stay frozen.

// File: rtl/line_readout_pkg.sv
package line_readout_pkg;
  typedef struct packed {
    logic capture;      // start accepted this edge
    logic resetActive;  // integrator reset window open
    logic outEn;        // scan in progress
  } seqStrobes_t;
endpackage

// File: rtl/line_readout_ctrl.sv
module line_readout_ctrl
  import line_readout_pkg::*;
#(
  parameter int NUM_PIX  = 128,
  parameter int RST_CLKS = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  output logic [NUM_PIX-1:0] pixSel,
  output logic               holdStb,
  output logic               intReset,
  output logic               outEn,
  output logic               protoErr,
  output seqStrobes_t        strobes
);
  localparam int CNT_W = $clog2(RST_CLKS + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             accept;

  assign accept = startIn && !outEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixSel   <= '0;
      outEn    <= 1'b0;
      holdStb  <= 1'b0;
      intReset <= 1'b0;
      rstCnt   <= '0;
      protoErr <= 1'b0;
    end else begin
      holdStb <= accept;
      if (startIn && outEn) protoErr <= 1'b1;
      if (accept) begin
        pixSel   <= NUM_PIX'(1);
        outEn    <= 1'b1;
        intReset <= 1'b1;
        rstCnt   <= CNT_W'(1);
      end else begin
        pixSel <= pixSel << 1;
        if (pixSel[NUM_PIX-1]) outEn <= 1'b0;
        if (intReset) begin
          if (rstCnt == CNT_W'(RST_CLKS)) intReset <= 1'b0;
          else rstCnt <= rstCnt + 1'b1;
        end
      end
    end
  end

  assign strobes.capture     = accept;
  assign strobes.resetActive = intReset;
  assign strobes.outEn       = outEn;

  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixSel));
  p_first_pixel_r3: assert property (@(posedge clk) disable iff (!rstN)
    holdStb |-> pixSel[0]);
  p_enable_tracks_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    outEn == (pixSel != '0));
  p_hold_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    holdStb |=> !holdStb);
  p_reset_opens_r4: assert property (@(posedge clk) disable iff (!rstN)
    holdStb |-> intReset);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

// File: rtl/line_readout_data.sv
module line_readout_data
  import line_readout_pkg::*;
#(
  parameter int NUM_PIX = 128,
  parameter int PIX_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              strobes,
  input  logic [NUM_PIX-1:0]       pixSel,
  input  logic [NUM_PIX*PIX_W-1:0] pixData,
  output logic [PIX_W-1:0]         pixOut,
  output logic [NUM_PIX-1:0]       sampleConn
);
  logic [NUM_PIX*PIX_W-1:0] heldVals;
  logic [NUM_PIX-1:0]       passedMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVals   <= '0;
      passedMask <= '1;
    end else if (strobes.capture) begin
      heldVals   <= pixData;
      passedMask <= '0;
    end else begin
      passedMask <= passedMask | pixSel;
    end
  end

  assign sampleConn = passedMask & {NUM_PIX{!strobes.resetActive}};

  always_comb begin
    pixOut = '0;
    for (int i = 0; i < NUM_PIX; i++)
      pixOut = pixOut | (heldVals[i*PIX_W +: PIX_W] & {PIX_W{pixSel[i]}});
  end

  p_hold_disconnect_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (sampleConn == '0));
  p_idle_connected_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.outEn && !strobes.resetActive) |-> (sampleConn == '1));
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.outEn |-> (pixOut == '0));
endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq
  import line_readout_pkg::*;
#(
  parameter int NUM_PIX  = 128,
  parameter int PIX_W    = 8,
  parameter int RST_CLKS = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startIn,
  input  logic [NUM_PIX*PIX_W-1:0] pixData,
  output logic [NUM_PIX-1:0]       pixSel,
  output logic                     holdStb,
  output logic                     intReset,
  output logic                     outEn,
  output logic [PIX_W-1:0]         pixOut,
  output logic [NUM_PIX-1:0]       sampleConn,
  output logic                     protoErr
);
  seqStrobes_t strobes;

  line_readout_ctrl #(.NUM_PIX(NUM_PIX), .RST_CLKS(RST_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .pixSel(pixSel), .holdStb(holdStb), .intReset(intReset),
    .outEn(outEn), .protoErr(protoErr), .strobes(strobes)
  );

  line_readout_data #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixSel(pixSel),
    .pixData(pixData), .pixOut(pixOut), .sampleConn(sampleConn)
  );
endmodule

// File: tb/line_readout_seq_bench.sv
module line_readout_seq_bench;
  localparam int NUM_PIX  = 128;
  localparam int PIX_W    = 8;
  localparam int RST_CLKS = 18;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     startIn = 1'b0;
  logic [NUM_PIX*PIX_W-1:0] pixData = '0;
  logic [NUM_PIX-1:0]       pixSel;
  logic                     holdStb, intReset, outEn, protoErr;
  logic [PIX_W-1:0]         pixOut;
  logic [NUM_PIX-1:0]       sampleConn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  line_readout_seq #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W), .RST_CLKS(RST_CLKS)) u_line_readout_seq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .pixData(pixData),
    .pixSel(pixSel), .holdStb(holdStb), .intReset(intReset), .outEn(outEn),
    .pixOut(pixOut), .sampleConn(sampleConn), .protoErr(protoErr)
  );

  function automatic logic [NUM_PIX*PIX_W-1:0] buildBus(int seed);
    logic [NUM_PIX*PIX_W-1:0] b;
    for (int i = 0; i < NUM_PIX; i++) b[i*PIX_W +: PIX_W] = PIX_W'(i * 37 + seed);
    return b;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(string tag, bit errExp);
    check(pixSel == '0, {tag, " pixSel"}, longint'(pixSel[63:0]), 0);
    check(outEn == 1'b0, {tag, " outEn"}, outEn, 0);
    check(pixOut == '0, "R6 pixOut idle", pixOut, 0);
    check(holdStb == 1'b0, {tag, " holdStb"}, holdStb, 0);
    check(intReset == 1'b0, {tag, " intReset"}, intReset, 0);
    check(sampleConn == '1, "R7 sampleConn idle", longint'(sampleConn[63:0]), -1);
    check(protoErr == errExp, {tag, " protoErr"}, protoErr, errExp);
  endtask

  // Runs one full scan; called at a falling edge, returns at the falling edge after the terminating edge.
  task automatic runScan(int seed, int injectAt, int swapAt, bit errAfter);
    logic [NUM_PIX*PIX_W-1:0] frozen;
    logic [NUM_PIX-1:0] expConn;
    frozen  = buildBus(seed);
    pixData = frozen;
    startIn = 1'b1;
    for (int k = 1; k <= NUM_PIX; k++) begin
      @(negedge clk);
      startIn = (k == injectAt);
      if (k == swapAt) pixData = buildBus(seed + 99);
      check(holdStb == (k == 1), "R2 holdStb", holdStb, (k == 1));
      check(pixSel == (NUM_PIX'(1) << (k - 1)), "R3 pixSel", k, k);
      check(pixOut == frozen[(k-1)*PIX_W +: PIX_W], "R3 pixOut",
            pixOut, frozen[(k-1)*PIX_W +: PIX_W]);
      check(intReset == (k <= RST_CLKS), "R4 intReset", intReset, (k <= RST_CLKS));
      check(outEn == 1'b1, "R5 outEn", outEn, 1);
      expConn = '0;
      if (k > RST_CLKS)
        for (int j = 0; j < k - 1; j++) expConn[j] = 1'b1;
      check(sampleConn == expConn, "R7 sampleConn", longint'(sampleConn[63:0]),
            longint'(expConn[63:0]));
      if (k > injectAt && injectAt > 0)
        check(protoErr == 1'b1, "R8 protoErr set", protoErr, 1);
    end
    @(negedge clk);
    startIn = 1'b0;
    checkIdle("R5 end", errAfter);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkIdle("R1 reset", 1'b0);
    @(negedge clk);
    checkIdle("R1 after reset", 1'b0);
  endtask

  task automatic testBasic();
    runScan(5, 0, 0, 1'b0);
    @(negedge clk);
    checkIdle("R6 stays idle", 1'b0);
  endtask

  task automatic testFrozen();      // R2: bus changes mid-scan are not seen
    runScan(11, 0, 60, 1'b0);
  endtask

  task automatic testBackToBack();  // R9
    runScan(21, 0, 0, 1'b0);
    runScan(40, 0, 0, 1'b0);
  endtask

  task automatic testBusyStart();   // R8
    runScan(77, 50, 0, 1'b1);
    repeat (2) @(negedge clk);
    check(protoErr == 1'b1, "R8 protoErr sticky", protoErr, 1);
    check(outEn == 1'b0, "R8 no second scan", outEn, 0);
    doReset();
  endtask

  initial begin
    @(negedge clk);
    doReset();
    testBasic();
    testFrozen();
    testBackToBack();
    testBusyStart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule